// File: doc/BRIEF.md
# Per-Core Aliased Register Window Decoder

This block decodes a small register window inside an interrupt controller that serves several processor cores. Each core owns a bank of per-core registers: a task-priority register and one interrupt acknowledge register per interprocessor-interrupt channel. A bank can be reached in two ways. Its normal address is unique to that core. It can also be reached through a shared private alias page, and there the requester ID on the bus picks the bank. Code that runs on any core can therefore use one fixed address and still reach its own registers.

The block also holds one dispatch register per interprocessor-interrupt channel, in the global page. A write to a dispatch register marks that channel pending for every core whose bit is set in the write data. Any requester can do this: a core, including the target core itself, or a bus master that is not a core. A non-core master can therefore use the dispatch registers as a doorbell. Pending bits appear on a flat output vector and stay set until the target core acknowledges them.

The bus is a single-cycle register port. A request is one cycle with `bus_sel` high. Read data comes back from a register on the following cycle. Priority arbitration and vector delivery are handled by other blocks.

Top module: `pic_alias_dec`

## Requirements
- R1: After reset, `bus_rdata` is zero, every bit of `ipi_pend` is zero and every task-priority register reads zero.
- R2: Read data for a read request (`bus_sel`=1, `bus_we`=0) appears on `bus_rdata` in the cycle after the request. In any cycle that follows a non-read, `bus_rdata` is zero.
- R3: Core n's bank sits at 0x6_0000 + n*0x1000 for n < NUM_CORES. Its task-priority register is at bank offset 0x080 and holds write-data bits [PRIO_W-1:0]. Upper read bits are zero.
- R4: An access to page 0x4_0xxx, at the same bank offset, reaches the bank of the core named by `bus_src`. The alias and the normal address reach the same physical register, so a write through one is read back through the other.
- R5: An alias access from a requester ID of NUM_CORES or above is not decoded. A read returns zero and a write changes no register and no pending bit.
- R6: Dispatch register k (k < NUM_CH) sits at 0x0_0040 + k*0x10. A write there sets the pending bit of channel k for every core c whose write-data bit c is 1. This works for any requester ID, including the targeted core itself and non-core masters.
- R7: The pending bit for core c, channel k, is `ipi_pend` bit c*NUM_CH+k. Once set, it stays set through idle cycles, reads, and dispatch writes with that target bit at 0.
- R8: Acknowledge register k of a bank sits at bank offset 0x0C0 + k*0x10 and can be reached through the normal or the alias address. A write with write-data bit 0 set clears that bank's core pending bit for channel k. A write with bit 0 clear has no effect. A read returns the pending bit in bit 0.
- R9: Any address not listed above reads as zero, and writes to it are ignored. This includes addresses with bits [3:0] nonzero, banks at or above NUM_CORES, dispatch offsets at or past channel NUM_CH, and reads of the dispatch registers.
- R10: The bank offset 0x080 of each core holds an independent value. A write to one core's bank leaves the other cores' task-priority values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_src | input | SRC_W | Requester ID; values below NUM_CORES are cores |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after a read |
| ipi_pend | output | NUM_CORES*NUM_CH | Pending interrupts, bit c*NUM_CH+k = core c, channel k |

## Verification
The bench builds the block with NUM_CORES=4, NUM_CH=4 and SRC_W=3. With these values, requester IDs 4 to 7 exercise the undecoded alias path. Normal bank numbers 4 and 5 fall past the last core, and dispatch offsets 0x080 and 0x090 fall past the last channel, so all three exercise the unmapped cases. All four channels and all four targets can be reached, so self-interrupts, multicast dispatch and cross-addressed acknowledges can each occur in both directed and random traffic.

// File: rtl/pic_alias_pkg.sv
package pic_alias_pkg;

  localparam int ADDR_W = 20;

  // Page numbers taken from address bits [19:12]
  localparam logic [7:0] PAGE_GLOBAL = 8'h00;
  localparam logic [7:0] PAGE_ALIAS  = 8'h40;
  // Normal per-core banks live under address bits [19:16] == 6
  localparam logic [3:0] NORMAL_HI   = 4'h6;

  // Register slots within a page, taken from address bits [11:4]
  localparam logic [7:0] SLOT_DISPATCH0 = 8'h04;
  localparam logic [7:0] SLOT_PRIO      = 8'h08;
  localparam logic [7:0] SLOT_ACK0      = 8'h0C;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_DISPATCH,
    ACC_PRIO,
    ACC_ACK
  } acc_kind_e;

endpackage

// File: rtl/pic_addr_decode.sv
module pic_addr_decode
  import pic_alias_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_CH    = 4,
  parameter int SRC_W     = 3,
  parameter int BANK_W    = 2,
  parameter int CH_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  src,
  output acc_kind_e         kind,
  output logic [BANK_W-1:0] bank,
  output logic [CH_W-1:0]   chan
);

  logic [7:0] page;
  logic [7:0] slot;
  logic       aligned;
  logic       in_bank;

  assign page    = addr[19:12];
  assign slot    = addr[11:4];
  assign aligned = (addr[3:0] == 4'h0);

  // The bank index comes from the requester on the alias page and from
  // the address on the normal pages.
  always_comb begin
    in_bank = 1'b0;
    bank    = '0;
    if (page == PAGE_ALIAS) begin
      if (int'(src) < NUM_CORES) begin
        in_bank = 1'b1;
        bank    = BANK_W'(src);
      end
    end else if ((addr[19:16] == NORMAL_HI) && (int'(addr[15:12]) < NUM_CORES)) begin
      in_bank = 1'b1;
      bank    = BANK_W'(addr[15:12]);
    end
  end

  always_comb begin
    kind = ACC_NONE;
    chan = '0;
    if (aligned) begin
      if ((page == PAGE_GLOBAL) && (slot >= SLOT_DISPATCH0) &&
          (int'(slot) < int'(SLOT_DISPATCH0) + NUM_CH)) begin
        kind = ACC_DISPATCH;
        chan = CH_W'(slot - SLOT_DISPATCH0);
      end else if (in_bank && (slot == SLOT_PRIO)) begin
        kind = ACC_PRIO;
      end else if (in_bank && (slot >= SLOT_ACK0) &&
                   (int'(slot) < int'(SLOT_ACK0) + NUM_CH)) begin
        kind = ACC_ACK;
        chan = CH_W'(slot - SLOT_ACK0);
      end
    end
  end

endmodule

// File: rtl/pic_core_bank.sv
module pic_core_bank #(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PRIO_W-1:0] wr_prio,
  output logic [PRIO_W-1:0] prio
);

  logic [PRIO_W-1:0] prio_d;
  logic [PRIO_W-1:0] prio_q;

  always_comb begin
    prio_d = prio_q;
    if (wr_en) prio_d = wr_prio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prio_q <= '0;
    else if (wr_en) prio_q <= prio_d;
  end

  assign prio = prio_q;

endmodule

// File: rtl/pic_ipi_pending.sv
module pic_ipi_pending #(
  parameter int NUM_CORES = 4,
  parameter int NUM_CH    = 4,
  parameter int BANK_W    = 2,
  parameter int CH_W      = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_en,
  input  logic [CH_W-1:0]             set_chan,
  input  logic [NUM_CORES-1:0]        set_mask,
  input  logic                        clr_en,
  input  logic [BANK_W-1:0]           clr_bank,
  input  logic [CH_W-1:0]             clr_chan,
  output logic [NUM_CORES*NUM_CH-1:0] pend
);

  localparam int NBITS = NUM_CORES * NUM_CH;

  logic [NBITS-1:0] set_vec;
  logic [NBITS-1:0] clr_vec;
  logic [NBITS-1:0] pend_d;
  logic [NBITS-1:0] pend_q;
  logic             upd;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      assign set_vec[c*NUM_CH+k] = set_en && set_mask[c] && (set_chan == CH_W'(k));
      assign clr_vec[c*NUM_CH+k] = clr_en && (clr_bank == BANK_W'(c)) &&
                                   (clr_chan == CH_W'(k));
    end
  end

  // A set overrides a clear of the same bit
  assign upd = set_en || clr_en;

  always_comb begin
    pend_d = (pend_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend = pend_q;

endmodule

// File: rtl/pic_alias_dec.sv
module pic_alias_dec
  import pic_alias_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 32,
  parameter int PRIO_W    = 4,
  parameter int SRC_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [19:0]                 bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic [SRC_W-1:0]            bus_src,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_CORES*NUM_CH-1:0] ipi_pend
);

  localparam int BANK_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // Reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  acc_kind_e         kind;
  logic [BANK_W-1:0] bank;
  logic [CH_W-1:0]   chan;

  pic_addr_decode #(
    .NUM_CORES(NUM_CORES),
    .NUM_CH   (NUM_CH),
    .SRC_W    (SRC_W),
    .BANK_W   (BANK_W),
    .CH_W     (CH_W)
  ) u_decode (
    .addr(bus_addr),
    .src (bus_src),
    .kind(kind),
    .bank(bank),
    .chan(chan)
  );

  logic wr_req;
  logic rd_req;
  logic unused_wdata;

  assign wr_req       = bus_sel && bus_we;
  assign rd_req       = bus_sel && !bus_we;
  assign unused_wdata = ^bus_wdata;

  // Per-core task-priority banks
  logic [PRIO_W-1:0] prio_arr [NUM_CORES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
    pic_core_bank #(.PRIO_W(PRIO_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .wr_en  (wr_req && (kind == ACC_PRIO) && (bank == BANK_W'(c))),
      .wr_prio(bus_wdata[PRIO_W-1:0]),
      .prio   (prio_arr[c])
    );
  end

  // Interprocessor pending state
  logic [NUM_CORES*NUM_CH-1:0] pend;

  pic_ipi_pending #(
    .NUM_CORES(NUM_CORES),
    .NUM_CH   (NUM_CH),
    .BANK_W   (BANK_W),
    .CH_W     (CH_W)
  ) u_pending (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_en  (wr_req && (kind == ACC_DISPATCH)),
    .set_chan(chan),
    .set_mask(bus_wdata[NUM_CORES-1:0]),
    .clr_en  (wr_req && (kind == ACC_ACK) && bus_wdata[0]),
    .clr_bank(bank),
    .clr_chan(chan),
    .pend    (pend)
  );

  logic [NUM_CH-1:0] pend_by_core [NUM_CORES];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_view
    assign pend_by_core[c] = pend[c*NUM_CH +: NUM_CH];
  end

  // Read path, registered
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    rd_d = '0;
    if (rd_req) begin
      case (kind)
        ACC_PRIO: rd_d[PRIO_W-1:0] = prio_arr[bank];
        ACC_ACK:  rd_d[0]          = pend_by_core[bank][chan];
        default:  rd_d             = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_q <= '0;
    else            rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;
  assign ipi_pend  = pend;

endmodule

// File: rtl/pic_alias_dec_chk.sv
module pic_alias_dec_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_CH    = 4,
  parameter int DATA_W    = 32,
  parameter int SRC_W     = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_sel,
  input logic                        bus_we,
  input logic [19:0]                 bus_addr,
  input logic                        wd_bit0,
  input logic [SRC_W-1:0]            bus_src,
  input logic [DATA_W-1:0]           bus_rdata,
  input logic [NUM_CORES*NUM_CH-1:0] ipi_pend
);

  logic page_known;
  assign page_known = (bus_addr[19:12] == 8'h00) || (bus_addr[19:12] == 8'h40) ||
                      ((bus_addr[19:16] == 4'h6) && (int'(bus_addr[15:12]) < NUM_CORES));

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> (bus_rdata == '0)); // R2

  AST_NONCORE_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && (bus_addr[19:12] == 8'h40) && (int'(bus_src) >= NUM_CORES))
    |=> (bus_rdata == '0)); // R5

  AST_PEND_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(ipi_pend)); // R7

  AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && !page_known) |=> $stable(ipi_pend)); // R9

  AST_DISPATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && (bus_addr == 20'h00040) && wd_bit0) |=> ipi_pend[0]); // R6

endmodule

bind pic_alias_dec pic_alias_dec_chk #(
  .NUM_CORES(NUM_CORES),
  .NUM_CH   (NUM_CH),
  .DATA_W   (DATA_W),
  .SRC_W    (SRC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wd_bit0  (bus_wdata[0]),
  .bus_src  (bus_src),
  .bus_rdata(bus_rdata),
  .ipi_pend (ipi_pend)
);

// File: tb/pic_alias_dec_tb.sv
`timescale 1ns/1ps
module pic_alias_dec_tb;

  localparam int NC = 4;
  localparam int NK = 4;
  localparam int DW = 32;
  localparam int SW = 3;

  logic          clk;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_we;
  logic [19:0]   bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [SW-1:0] bus_src;
  logic [DW-1:0] bus_rdata;
  logic [NC*NK-1:0] ipi_pend;

  pic_alias_dec #(.NUM_CORES(NC), .NUM_CH(NK), .DATA_W(DW), .PRIO_W(4), .SRC_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_src(bus_src), .bus_rdata(bus_rdata), .ipi_pend(ipi_pend)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  int          mprio [NC];
  logic [NC*NK-1:0] mpend;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // kind: 0 none, 1 dispatch, 2 priority, 3 acknowledge
  function automatic void bdec(input logic [19:0] a, input int s,
                               output int kind, output int bank, output int ch, output bit alias_pg);
    bit inb;
    int off;
    kind = 0; bank = 0; ch = 0; inb = 0;
    off = int'(a[11:0]);
    alias_pg = (a[19:12] == 8'h40);
    if (alias_pg) begin
      if (s < NC) begin bank = s; inb = 1; end
    end else if (a[19:16] == 4'h6 && int'(a[15:12]) < NC) begin
      bank = int'(a[15:12]); inb = 1;
    end
    if (a[19:12] == 8'h00 && off >= 'h40 && off < 'h40 + NK*16 && off % 16 == 0) begin
      kind = 1; ch = (off - 'h40) / 16;
    end else if (inb && off == 'h80) begin
      kind = 2;
    end else if (inb && off >= 'hC0 && off < 'hC0 + NK*16 && off % 16 == 0) begin
      kind = 3; ch = (off - 'hC0) / 16;
    end
  endfunction

  task automatic op(input bit s_sel, input bit s_we, input logic [19:0] a,
                    input logic [DW-1:0] d, input int s, input string tag_in);
    int kind, bank, ch;
    bit alias_pg;
    string tag;
    logic [DW-1:0] exp;
    bus_sel = s_sel; bus_we = s_we; bus_addr = a; bus_wdata = d; bus_src = SW'(s);
    bdec(a, s, kind, bank, ch, alias_pg);
    tag = tag_in;
    if (tag == "") begin
      if (!s_sel) tag = "R7";
      else if (kind == 1) tag = "R6";
      else if (kind == 2) tag = alias_pg ? "R4" : "R3";
      else if (kind == 3) tag = "R8";
      else if (alias_pg) tag = "R5";
      else tag = "R9";
    end
    exp = '0;
    if (s_sel && !s_we) begin
      if (kind == 2) exp = DW'(mprio[bank]);
      else if (kind == 3) exp = DW'(mpend[bank*NK+ch]);
    end
    if (s_sel && s_we) begin
      if (kind == 1) begin
        for (int c = 0; c < NC; c++) if (d[c]) mpend[c*NK+ch] = 1'b1;
      end else if (kind == 2) begin
        mprio[bank] = int'(d[3:0]);
      end else if (kind == 3 && d[0]) begin
        mpend[bank*NK+ch] = 1'b0;
      end
    end
    @(negedge clk);
    check({tag, " rdata"}, bus_rdata, exp);
    check({tag, " pend"}, DW'(ipi_pend), DW'(mpend));
  endtask

  function automatic logic [19:0] pick_off();
    case ($urandom_range(0, 6))
      0: return 20'h080;
      1: return 20'h0C0;
      2: return 20'h0D0;
      3: return 20'h0E0;
      4: return 20'h0F0;
      5: return 20'h084;
      default: return 20'h040;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NC; c++) mprio[c] = 0;
    mpend = '0;
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; bus_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 rdata", bus_rdata, '0);
    check("R1 pend", DW'(ipi_pend), '0);
    for (int c = 0; c < NC; c++) op(1, 0, 20'h60080 + 20'(c << 12), '0, 0, "R1");

    // R2: read data follows one cycle later, zero after a non-read
    op(1, 1, 20'h61080, 32'h7, 0, "R3");
    op(1, 0, 20'h61080, '0, 0, "R2");
    op(0, 0, 20'h61080, '0, 0, "R2");

    // R3/R4: normal and alias reach the same register
    op(1, 1, 20'h62080, 32'hFFFF_FFFA, 0, "R3");
    op(1, 0, 20'h40080, '0, 2, "R4");
    op(1, 1, 20'h40080, 32'h5, 1, "R4");
    op(1, 0, 20'h61080, '0, 3, "R4");
    // R10: other banks untouched
    op(1, 0, 20'h60080, '0, 0, "R10");
    op(1, 0, 20'h63080, '0, 0, "R10");

    // R5: non-core alias access
    op(1, 1, 20'h40080, 32'hC, 5, "R5");
    op(1, 0, 20'h40080, '0, 6, "R5");
    op(1, 0, 20'h61080, '0, 1, "R5");

    // R6: doorbell from non-core, self interrupt, multicast
    op(1, 1, 20'h00070, 32'h5, 6, "R6");
    op(1, 1, 20'h00050, 32'h2, 1, "R6");
    op(1, 1, 20'h00040, 32'hF, 0, "R6");
    // R7: holds through idle, reads and zero-bit dispatch
    op(0, 1, 20'h000C0, 32'h1, 0, "R7");
    op(1, 1, 20'h00040, 32'h0, 2, "R7");
    op(1, 0, 20'h600C0, '0, 0, "R7");

    // R8: acknowledge through alias and normal, bit 0 clear ignored
    op(1, 1, 20'h400D0, 32'hE, 1, "R8");
    op(1, 0, 20'h410D0, '0, 0, "R8");
    op(1, 1, 20'h400D0, 32'h1, 1, "R8");
    op(1, 0, 20'h400D0, '0, 1, "R8");
    op(1, 1, 20'h620F0, 32'h1, 0, "R8");

    // R9: unmapped
    op(1, 0, 20'h60084, '0, 0, "R9");
    op(1, 0, 20'h64080, '0, 0, "R9");
    op(1, 1, 20'h64080, 32'h9, 0, "R9");
    op(1, 1, 20'h00080, 32'hF, 0, "R9");
    op(1, 0, 20'h00040, '0, 0, "R9");
    op(1, 1, 20'h600C4, 32'h1, 0, "R9");

    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [19:0] a;
      int cat;
      cat = $urandom_range(0, 4);
      case (cat)
        0: a = 20'h00040 + 20'($urandom_range(0, 5) << 4);
        1: a = 20'h60000 + 20'($urandom_range(0, 5) << 12) + pick_off();
        2: a = 20'h40000 + pick_off();
        3: a = 20'($urandom);
        default: a = 20'h40000 + pick_off();
      endcase
      op(($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), a, $urandom,
         $urandom_range(0, 7), "");
    end

    op(0, 0, '0, '0, 0, "R2");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule